// File: doc/BRIEF.md
# Boosted Speculation Shadow Register File

This block holds the architectural integer registers of a statically scheduled core together with a parallel set of shadow registers and a small shadow store queue. The compiler may hoist instructions above one predicted branch and mark them as boosted. Their register results land in the shadow copy, their stores wait in the queue, and any exception they raise is remembered rather than reported. Readers flagged as boosted see the speculative value of a register when one exists. Other readers see only architectural state.

When the branch resolves, a correct prediction with no remembered exception copies every valid shadow entry into the architectural registers in a single cycle. The queued stores then leave on the memory port in the order they were accepted, one per cycle. A wrong prediction discards the shadow entries, the queue and the remembered exception. Boosted operations that arrive in the same cycle as the resolve are squashed. A correct prediction with a remembered exception reports the destination register of the faulting instruction and discards the speculative state instead of committing it. A boosted instruction that is still in flight in the resolve cycle is treated as no longer boosted and writes the architectural state directly.

The controller has three states. ST_IDLE means no speculative state is held. ST_SPEC means shadow entries, queued stores or a remembered exception exist. ST_DRAIN means committed stores are leaving the queue. ST_IDLE and ST_SPEC both move to ST_IDLE on a resolve, except that a correct resolve that leaves the queue non-empty moves to ST_DRAIN. ST_IDLE moves to ST_SPEC when a boosted write, store or exception is accepted. ST_DRAIN leaves on the cycle that pops the last entry. It goes to ST_SPEC if new shadow entries or a remembered exception exist, and to ST_IDLE otherwise. The branch unit must not present a resolve while ST_DRAIN is active.

Top module: `spec_shadow_rf`

## Requirements
- R1: After reset every architectural register reads zero on both read ports, no shadow entry is valid, and mem_we, exc_valid and st_stall are 0.
- R2: A write without the boost flag updates the architectural register at the next clock edge. With no valid shadow entry for that register, readers of either kind then return the new value.
- R3: A write with the boost flag updates only the shadow copy. A non-boosted read of that register still returns the architectural value, and a boosted read returns the shadow value.
- R4: A non-boosted store accepted outside ST_DRAIN appears on the memory port in the following cycle. A boosted store accepted before the resolve never appears there before a correct resolve.
- R5: A correct resolve with no remembered exception copies every valid shadow entry into the architectural registers in one cycle and clears all shadow valid bits.
- R6: After such a commit, queued stores reach the memory port one per cycle in acceptance order. While they drain, st_stall is 1 for every presented store, and that store is not accepted.
- R7: A wrong resolve clears every shadow entry and empties the store queue. None of the discarded stores ever reaches memory, and a boosted write or store presented in the same cycle is discarded.
- R8: In a correct-resolve cycle, a boosted write goes to the architectural register and takes priority over the shadow value. A non-boosted write to a register with a valid shadow entry is overwritten by the shadow value. A store of either kind joins the tail of a non-empty queue, or goes straight to memory when the queue is empty.
- R9: An exception flagged on a boosted write is not reported when it occurs. Only the first such exception is remembered until the resolve.
- R10: A correct resolve with a remembered exception raises exc_valid for one cycle, one cycle later, with exc_idx equal to the faulting destination. Nothing is committed, and the shadow entries and queued stores are discarded.
- R11: A wrong resolve clears a remembered exception without reporting it.
- R12: An exception flagged on a non-boosted write raises exc_valid in the next cycle, with exc_idx equal to that write's destination.
- R13: A boosted store presented outside a resolve cycle while the queue holds SB_DEPTH entries sees st_stall high in the same cycle and is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write request |
| wr_boost | input | 1 | Write comes from a boosted instruction |
| wr_exc | input | 1 | The writing instruction raised an exception |
| wr_idx | input | AW | Destination register |
| wr_data | input | DW | Write value |
| rd0_idx | input | AW | Read port 0 register |
| rd0_boost | input | 1 | Read port 0 reader is boosted |
| rd0_data | output | DW | Read port 0 value (combinational) |
| rd1_idx | input | AW | Read port 1 register |
| rd1_boost | input | 1 | Read port 1 reader is boosted |
| rd1_data | output | DW | Read port 1 value (combinational) |
| st_en | input | 1 | Store request |
| st_boost | input | 1 | Store comes from a boosted instruction |
| st_addr | input | MAW | Store address |
| st_data | input | DW | Store value |
| st_stall | output | 1 | Store not accepted this cycle |
| br_valid | input | 1 | Branch resolve strobe |
| br_correct | input | 1 | The prediction was correct |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | MAW | Memory write address |
| mem_data | output | DW | Memory write value |
| exc_valid | output | 1 | Exception report strobe |
| exc_idx | output | AW | Destination register of the faulting instruction |

## Verification
The bench goes after collisions in the resolve cycle. A boosted write to the same register as a pending shadow entry must win, and a design with the wrong priority would leave the stale shadow value. A non-boosted write there must lose, and reversed priority would show the pre-branch value. A store in that cycle must follow the queued stores, or it would overtake them on the memory port. It also fills the queue to its limit to check that the overflowing store is refused rather than overwriting the oldest entry. After a wrong resolve, a later correct resolve must not release old stores, which a design that only cleared a head pointer might do. For exceptions, the bench checks that only the first boosted exception is reported. A remembered exception must block the commit, and a design that committed anyway would expose speculative register values. A wrong resolve must clear the remembered exception, or a later clean commit would raise a stale fault.

// File: rtl/spec_shadow_pkg.sv
package spec_shadow_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPEC  = 2'd1,
        ST_DRAIN = 2'd2
    } spec_state_e;

endpackage

// File: rtl/spec_shadow_regs.sv
module spec_shadow_regs #(
    parameter int NREG = 8,
    parameter int DW   = 16,
    parameter int NRD  = 2,
    localparam int AW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic              arch_lo_we,
    input  logic              arch_hi_we,
    input  logic              sh_we,
    input  logic              commit,
    input  logic              sh_clear,
    input  logic [NRD*AW-1:0] rd_idx,
    input  logic [NRD-1:0]    rd_boost,
    output logic [NRD*DW-1:0] rd_data,
    output logic              sh_any
);

    logic [NREG-1:0][DW-1:0] arch_q;
    logic [NREG-1:0][DW-1:0] sh_q;
    logic [NREG-1:0]         sval_q;

    // Architectural priority per register: in-flight boosted write,
    // then committed shadow value, then ordinary write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arch_q <= '0;
            sh_q   <= '0;
            sval_q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (arch_hi_we && wr_idx == AW'(i)) begin
                    arch_q[i] <= wr_data;
                end else if (commit && sval_q[i]) begin
                    arch_q[i] <= sh_q[i];
                end else if (arch_lo_we && wr_idx == AW'(i)) begin
                    arch_q[i] <= wr_data;
                end
                if (sh_we && wr_idx == AW'(i)) begin
                    sh_q[i] <= wr_data;
                end
                if (sh_clear) begin
                    sval_q[i] <= 1'b0;
                end else if (sh_we && wr_idx == AW'(i)) begin
                    sval_q[i] <= 1'b1;
                end
            end
        end
    end

    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            logic [AW-1:0] ix;
            assign ix = rd_idx[p*AW +: AW];
            assign rd_data[p*DW +: DW] = (rd_boost[p] && sval_q[ix]) ? sh_q[ix] : arch_q[ix];
        end
    endgenerate

    assign sh_any = |sval_q;

endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf #(
    parameter int DEPTH = 4,
    parameter int W     = 24,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  head,
    output logic [CW-1:0] cnt,
    output logic          empty,
    output logic          full
);

    logic [DEPTH-1:0][W-1:0] slot_q;
    logic [PW-1:0]           rp_q;
    logic [PW-1:0]           wp_q;
    logic [CW-1:0]           cnt_q;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            slot_q[wp_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_q  <= '0;
            wp_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            rp_q  <= '0;
            wp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= nxt(wp_q);
            if (pop)  rp_q <= nxt(rp_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    assign head  = slot_q[rp_q];
    assign cnt   = cnt_q;
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/spec_ctrl.sv
module spec_ctrl
    import spec_shadow_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          br_valid,
    input  logic          br_correct,
    input  logic          wr_en,
    input  logic          wr_boost,
    input  logic          wr_exc,
    input  logic [AW-1:0] wr_idx,
    input  logic          st_en,
    input  logic          st_boost,
    input  logic          sb_empty,
    input  logic          sb_full,
    input  logic          sb_last,
    input  logic          sh_any,
    output logic          arch_lo_we,
    output logic          arch_hi_we,
    output logic          sh_we,
    output logic          commit,
    output logic          sh_clear,
    output logic          sb_push,
    output logic          sb_pop,
    output logic          sb_flush,
    output logic          mem_direct,
    output logic          st_stall,
    output logic          exc_valid,
    output logic [AW-1:0] exc_idx,
    output spec_state_e   state,
    output logic          exc_pend
);

    spec_state_e   state_q, state_d;
    logic          exc_pend_q;
    logic [AW-1:0] exc_idx_q;
    logic          drain, rsv, kill, conf_exc;
    logic          join_tail, spec_st, push_req;
    logic          exc_set, exc_now;

    // State register and exception bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            exc_pend_q <= 1'b0;
            exc_idx_q  <= '0;
            exc_valid  <= 1'b0;
            exc_idx    <= '0;
        end else begin
            state_q <= state_d;
            if (kill) begin
                exc_pend_q <= 1'b0;
            end else if (exc_set) begin
                exc_pend_q <= 1'b1;
                exc_idx_q  <= wr_idx;
            end
            exc_valid <= conf_exc | exc_now;
            exc_idx   <= conf_exc ? exc_idx_q : wr_idx;
        end
    end

    // Outputs and next state.
    always_comb begin
        drain      = (state_q == ST_DRAIN);
        rsv        = br_valid & ~drain;
        commit     = rsv & br_correct & ~exc_pend_q;
        kill       = rsv & (~br_correct | exc_pend_q);
        conf_exc   = rsv & br_correct & exc_pend_q;

        arch_lo_we = wr_en & ~wr_boost;
        arch_hi_we = wr_en & wr_boost & commit;
        sh_we      = wr_en & wr_boost & ~rsv;
        sh_clear   = commit | kill;

        join_tail  = st_en & commit & ~sb_empty;
        spec_st    = st_en & st_boost & ~rsv & ~drain;
        push_req   = join_tail | spec_st;
        st_stall   = st_en & (drain | (push_req & sb_full));
        sb_push    = push_req & ~sb_full;
        mem_direct = st_en & ~drain & ~push_req & ~(st_boost & kill);
        sb_pop     = drain & ~sb_empty;
        sb_flush   = kill;

        exc_set    = wr_en & wr_boost & wr_exc & ~rsv & ~exc_pend_q;
        exc_now    = wr_en & wr_exc & (~wr_boost | commit);

        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_SPEC: begin
                if (commit && !sb_empty)              state_d = ST_DRAIN;
                else if (rsv)                         state_d = ST_IDLE;
                else if (sh_we || sb_push || exc_set) state_d = ST_SPEC;
            end
            ST_DRAIN: begin
                if (sb_last) begin
                    state_d = (sh_any || sh_we || exc_pend_q || exc_set) ? ST_SPEC : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase

        state    = state_q;
        exc_pend = exc_pend_q;
    end

endmodule

// File: rtl/spec_shadow_rf.sv
module spec_shadow_rf
    import spec_shadow_pkg::*;
#(
    parameter int NREG     = 8,
    parameter int DW       = 16,
    parameter int MAW      = 8,
    parameter int SB_DEPTH = 4,
    localparam int AW      = $clog2(NREG),
    localparam int SW      = MAW + DW,
    localparam int CW      = $clog2(SB_DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_boost,
    input  logic           wr_exc,
    input  logic [AW-1:0]  wr_idx,
    input  logic [DW-1:0]  wr_data,
    input  logic [AW-1:0]  rd0_idx,
    input  logic           rd0_boost,
    output logic [DW-1:0]  rd0_data,
    input  logic [AW-1:0]  rd1_idx,
    input  logic           rd1_boost,
    output logic [DW-1:0]  rd1_data,
    input  logic           st_en,
    input  logic           st_boost,
    input  logic [MAW-1:0] st_addr,
    input  logic [DW-1:0]  st_data,
    output logic           st_stall,
    input  logic           br_valid,
    input  logic           br_correct,
    output logic           mem_we,
    output logic [MAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_data,
    output logic           exc_valid,
    output logic [AW-1:0]  exc_idx
);

    logic          arch_lo_we, arch_hi_we, sh_we, commit, sh_clear, sh_any;
    logic          sb_push, sb_pop, sb_flush, sb_empty, sb_full, sb_last;
    logic          mem_direct, exc_pend;
    logic [SW-1:0] sb_head;
    logic [CW-1:0] sb_cnt;
    spec_state_e   state_w;
    logic [2*DW-1:0] rd_bus;

    spec_shadow_regs #(.NREG(NREG), .DW(DW), .NRD(2)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .arch_lo_we (arch_lo_we),
        .arch_hi_we (arch_hi_we),
        .sh_we      (sh_we),
        .commit     (commit),
        .sh_clear   (sh_clear),
        .rd_idx     ({rd1_idx, rd0_idx}),
        .rd_boost   ({rd1_boost, rd0_boost}),
        .rd_data    (rd_bus),
        .sh_any     (sh_any)
    );

    assign rd0_data = rd_bus[DW-1:0];
    assign rd1_data = rd_bus[2*DW-1:DW];

    spec_store_buf #(.DEPTH(SB_DEPTH), .W(SW)) u_sbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (sb_push),
        .push_data ({st_addr, st_data}),
        .pop       (sb_pop),
        .flush     (sb_flush),
        .head      (sb_head),
        .cnt       (sb_cnt),
        .empty     (sb_empty),
        .full      (sb_full)
    );

    assign sb_last = (sb_cnt == CW'(1));

    spec_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .br_valid   (br_valid),
        .br_correct (br_correct),
        .wr_en      (wr_en),
        .wr_boost   (wr_boost),
        .wr_exc     (wr_exc),
        .wr_idx     (wr_idx),
        .st_en      (st_en),
        .st_boost   (st_boost),
        .sb_empty   (sb_empty),
        .sb_full    (sb_full),
        .sb_last    (sb_last),
        .sh_any     (sh_any),
        .arch_lo_we (arch_lo_we),
        .arch_hi_we (arch_hi_we),
        .sh_we      (sh_we),
        .commit     (commit),
        .sh_clear   (sh_clear),
        .sb_push    (sb_push),
        .sb_pop     (sb_pop),
        .sb_flush   (sb_flush),
        .mem_direct (mem_direct),
        .st_stall   (st_stall),
        .exc_valid  (exc_valid),
        .exc_idx    (exc_idx),
        .state      (state_w),
        .exc_pend   (exc_pend)
    );

    // Memory port: direct stores and drained entries never coincide.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
        end else begin
            mem_we <= mem_direct | sb_pop;
            if (sb_pop) begin
                mem_addr <= sb_head[SW-1:DW];
                mem_data <= sb_head[DW-1:0];
            end else if (mem_direct) begin
                mem_addr <= st_addr;
                mem_data <= st_data;
            end
        end
    end

endmodule

// File: rtl/spec_shadow_chk.sv
module spec_shadow_chk
    import spec_shadow_pkg::*;
#(
    parameter int CW    = 3,
    parameter int DEPTH = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          br_valid,
    input logic          br_correct,
    input logic          st_en,
    input logic          st_boost,
    input logic          st_stall,
    input logic          wr_en,
    input logic          wr_exc,
    input logic          exc_valid,
    input logic          mem_we,
    input spec_state_e   state,
    input logic          exc_pend,
    input logic          sh_any,
    input logic [CW-1:0] sb_cnt,
    input logic          sb_full
);

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && st_boost && sb_full && !br_valid && state != ST_DRAIN) |-> st_stall); // R13

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sb_cnt <= CW'(DEPTH)); // R13

    AST_KILL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !br_correct && state != ST_DRAIN) |=> (!sh_any && sb_cnt == '0)); // R7

    AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> $past(br_valid || (wr_en && wr_exc))); // R9

    AST_EXC_ON_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_correct && exc_pend && state != ST_DRAIN) |=> (exc_valid && !sh_any)); // R10

    AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |=> (sb_cnt == CW'($past(sb_cnt) - 1'b1))); // R6

    AST_DRAIN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && st_en) |-> st_stall); // R6

    AST_MEM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past((st_en && !st_stall) || state == ST_DRAIN)); // R4

endmodule

bind spec_shadow_rf spec_shadow_chk #(.CW(CW), .DEPTH(SB_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_valid   (br_valid),
    .br_correct (br_correct),
    .st_en      (st_en),
    .st_boost   (st_boost),
    .st_stall   (st_stall),
    .wr_en      (wr_en),
    .wr_exc     (wr_exc),
    .exc_valid  (exc_valid),
    .mem_we     (mem_we),
    .state      (state_w),
    .exc_pend   (exc_pend),
    .sh_any     (sh_any),
    .sb_cnt     (sb_cnt),
    .sb_full    (sb_full)
);

// File: tb/sim_spec_shadow_rf.sv
`timescale 1ns/1ps
module sim_spec_shadow_rf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, wr_boost = 0, wr_exc = 0;
    logic [2:0]  wr_idx = 0;
    logic [15:0] wr_data = 0;
    logic [2:0]  rd0_idx = 0, rd1_idx = 0;
    logic        rd0_boost = 0, rd1_boost = 1;
    logic [15:0] rd0_data, rd1_data;
    logic        st_en = 0, st_boost = 0;
    logic [7:0]  st_addr = 0;
    logic [15:0] st_data = 0;
    logic        st_stall;
    logic        br_valid = 0, br_correct = 0;
    logic        mem_we;
    logic [7:0]  mem_addr;
    logic [15:0] mem_data;
    logic        exc_valid;
    logic [2:0]  exc_idx;

    int checks = 0;
    int errors = 0;
    logic [23:0] mq[$];
    logic [2:0]  eq[$];

    always #2.5 clk = ~clk;

    spec_shadow_rf u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_boost(wr_boost), .wr_exc(wr_exc), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd0_idx(rd0_idx), .rd0_boost(rd0_boost), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_boost(rd1_boost), .rd1_data(rd1_data),
        .st_en(st_en), .st_boost(st_boost), .st_addr(st_addr), .st_data(st_data), .st_stall(st_stall),
        .br_valid(br_valid), .br_correct(br_correct),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .exc_valid(exc_valid), .exc_idx(exc_idx)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard queues as results appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (mq.size() == 0) begin
                    check(1'b0, "R4/R7 unexpected store", {mem_addr, mem_data}, 0);
                end else begin
                    logic [23:0] e;
                    e = mq.pop_front();
                    check({mem_addr, mem_data} === e, "R6 store order", {mem_addr, mem_data}, e);
                end
            end
            if (exc_valid) begin
                if (eq.size() == 0) begin
                    check(1'b0, "R9/R11 unexpected exception", exc_idx, 0);
                end else begin
                    logic [2:0] x;
                    x = eq.pop_front();
                    check(exc_idx === x, "R10/R12 exception index", exc_idx, x);
                end
            end
        end
    end

    task automatic set_wr(input bit b, input int idx, input logic [15:0] d, input bit e);
        wr_en = 1; wr_boost = b; wr_idx = idx[2:0]; wr_data = d; wr_exc = e;
    endtask

    task automatic set_st(input bit b, input logic [7:0] a, input logic [15:0] d);
        st_en = 1; st_boost = b; st_addr = a; st_data = d;
    endtask

    task automatic set_br(input bit c);
        br_valid = 1; br_correct = c;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        wr_en = 0; wr_boost = 0; wr_exc = 0;
        st_en = 0; st_boost = 0;
        br_valid = 0; br_correct = 0;
    endtask

    task automatic chk_rd(input int idx, input logic [15:0] ea, input logic [15:0] eb, input string req);
        @(negedge clk);
        rd0_idx = idx[2:0]; rd0_boost = 0;
        rd1_idx = idx[2:0]; rd1_boost = 1;
        #1;
        check(rd0_data === ea, {req, " plain read"}, rd0_data, ea);
        check(rd1_data === eb, {req, " boosted read"}, rd1_data, eb);
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        for (int i = 0; i < 8; i++) chk_rd(i, 16'h0, 16'h0, "R1");
        check(mem_we === 0 && exc_valid === 0 && st_stall === 0, "R1 idle outputs", {mem_we, exc_valid, st_stall}, 0);

        // R2 ordinary write
        @(negedge clk); set_wr(0, 1, 16'h1111, 0); tick();
        chk_rd(1, 16'h1111, 16'h1111, "R2");

        // R3 boosted write stays in shadow
        @(negedge clk); set_wr(1, 1, 16'hAAAA, 0); tick();
        chk_rd(1, 16'h1111, 16'hAAAA, "R3");
        chk_rd(2, 16'h0, 16'h0, "R3 untouched");

        // R4 direct store vs held boosted store
        @(negedge clk); set_st(0, 8'h10, 16'h0010); mq.push_back({8'h10, 16'h0010}); tick();
        @(negedge clk); set_st(1, 8'h20, 16'h0020); tick();
        settle(4);
        check(mq.size() == 0, "R4 boosted store held", mq.size(), 0);

        // R5 commit, R6 release
        @(negedge clk); set_br(1); mq.push_back({8'h20, 16'h0020}); tick();
        chk_rd(1, 16'hAAAA, 16'hAAAA, "R5");
        settle(4);
        check(mq.size() == 0, "R6 buffered store released", mq.size(), 0);

        // R8 boosted write in commit cycle beats shadow
        @(negedge clk); set_wr(1, 3, 16'h3333, 0); tick();
        @(negedge clk); set_br(1); set_wr(1, 3, 16'h4444, 0); tick();
        chk_rd(3, 16'h4444, 16'h4444, "R8 in-flight boosted write");

        // R8 plain write in commit cycle loses to shadow
        @(negedge clk); set_wr(1, 1, 16'hBBBB, 0); tick();
        @(negedge clk); set_br(1); set_wr(0, 1, 16'h5555, 0); tick();
        chk_rd(1, 16'hBBBB, 16'hBBBB, "R8 shadow over plain write");

        // R8 store in commit cycle joins queue tail
        @(negedge clk); set_st(1, 8'h30, 16'h0030); tick();
        @(negedge clk); set_br(1); set_st(0, 8'h31, 16'h0031);
        mq.push_back({8'h30, 16'h0030}); mq.push_back({8'h31, 16'h0031}); tick();
        settle(5);
        check(mq.size() == 0, "R8 tail order", mq.size(), 0);

        // R8 boosted store in commit cycle with empty queue goes straight out
        @(negedge clk); set_br(1); set_st(1, 8'h40, 16'h0040); mq.push_back({8'h40, 16'h0040}); tick();
        settle(3);
        check(mq.size() == 0, "R8 direct store", mq.size(), 0);

        // R7 mispredict flush
        @(negedge clk); set_wr(1, 4, 16'hBEEF, 0); tick();
        @(negedge clk); set_st(1, 8'h50, 16'h0050); tick();
        @(negedge clk); set_br(0); set_wr(1, 5, 16'h5A5A, 0); set_st(1, 8'h51, 16'h0051); tick();
        chk_rd(4, 16'h0, 16'h0, "R7 shadow flushed");
        chk_rd(5, 16'h0, 16'h0, "R7 same-cycle boosted write squashed");
        @(negedge clk); set_br(1); tick();
        settle(5);
        check(mq.size() == 0, "R7 no flushed store", mq.size(), 0);
        chk_rd(4, 16'h0, 16'h0, "R7 later commit");

        // R13 full queue stall, R6 stall while draining
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); set_st(1, 8'h60 + 8'(k), 16'h0600 + 16'(k)); tick();
        end
        @(negedge clk); set_st(1, 8'h64, 16'h0604); #1;
        check(st_stall === 1, "R13 stall when full", st_stall, 1);
        tick();
        @(negedge clk); set_br(1);
        for (int k = 0; k < 4; k++) mq.push_back({8'h60 + 8'(k), 16'h0600 + 16'(k)});
        tick();
        @(negedge clk); set_st(0, 8'h70, 16'h0070); #1;
        check(st_stall === 1, "R6 stall during drain", st_stall, 1);
        tick();
        settle(6);
        check(mq.size() == 0, "R6/R13 drained exactly four", mq.size(), 0);

        // R9 deferral, R10 confirm with exception
        @(negedge clk); set_wr(1, 6, 16'h6666, 1); tick();
        settle(2);
        check(exc_valid === 0, "R9 deferred", exc_valid, 0);
        @(negedge clk); set_wr(1, 2, 16'h2222, 1); tick();
        @(negedge clk); set_wr(1, 7, 16'h7777, 0); tick();
        @(negedge clk); set_st(1, 8'h80, 16'h0080); tick();
        @(negedge clk); set_br(1); eq.push_back(3'd6); tick();
        settle(4);
        check(eq.size() == 0, "R10 exception reported", eq.size(), 0);
        chk_rd(7, 16'h0, 16'h0, "R10 no commit");
        chk_rd(2, 16'h0, 16'h0, "R10 no commit");
        check(mq.size() == 0, "R10 store dropped", mq.size(), 0);

        // R11 mispredict clears remembered exception
        @(negedge clk); set_wr(1, 6, 16'h6060, 1); tick();
        @(negedge clk); set_br(0); tick();
        @(negedge clk); set_wr(1, 6, 16'h0606, 0); tick();
        @(negedge clk); set_br(1); tick();
        settle(3);
        chk_rd(6, 16'h0606, 16'h0606, "R11 clean commit");
        check(eq.size() == 0, "R11 no stale report", eq.size(), 0);

        // R12 immediate report for ordinary write
        @(negedge clk); set_wr(0, 0, 16'h00EE, 1); eq.push_back(3'd0); tick();
        settle(3);
        check(eq.size() == 0, "R12 immediate report", eq.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule